// File: doc/BRIEF.md
# Token-Ring Depth Expansion FIFO

This block builds one deep first-in first-out buffer out of several identical storage devices joined in a ring. Each device has its own small RAM, a write token and a read token. Only the device holding the write token accepts writes and only the device holding the read token serves reads. When a device accesses its highest address, it gives up the matching token and raises a one-cycle expansion pulse toward its ring successor. The successor picks the token up on the following edge. A per-device first-load input, active low, chooses which device starts with both tokens.

Write data fills device after device, and reads follow the same path. A simple merger combines the per-device flags and read data into chain-level outputs. With a single device, no token ever moves and the shared pin of the device carries a half-full flag instead of the write expansion pulse.

Top module: `fifo_depth_chain`

## Requirements
- R1: During reset and right after it, the device whose `first_load_n` bit is 0 holds both tokens and every other device holds none. Chain `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: A write is taken only by the write-token holder, and only when that device is not full. It goes into that device's next free address.
- R3: In the edge where the holder writes address DEPTH-1, it drops the write token and drives its write expansion pulse high for exactly one cycle. During that cycle no device holds the write token.
- R4: Device (i+1) mod NUM_DEV takes the write token on the edge that ends device i's pulse, so the last device hands back to the first.
- R5: Reads pass the read token in the same way: after the read of address DEPTH-1 there is a one-cycle gap, then the ring successor holds the token.
- R6: `rd_en` asserted to a read-token holder that is not empty makes `rd_valid` 1 one cycle later. Otherwise `rd_valid` is 0 and `rd_data` is all zeros.
- R7: Enables asserted while no device holds the matching token, or when a write meets a full holder, change no storage, flag or token.
- R8: Words leave the chain in the order they were written, across device boundaries.
- R9: Chain `empty` is 1 exactly when every device is empty. Chain `full` is 1 exactly when every device is full, giving a capacity of NUM_DEV*DEPTH words.
- R10: With NUM_DEV=1, `half_full` is 1 while more than DEPTH/2 words are stored, and the token never leaves the device. With NUM_DEV>1, `half_full` stays 0.
- R11: At no time do two devices hold the same token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all devices |
| rst_n | input | 1 | Active-low synchronous reset |
| first_load_n | input | NUM_DEV | Per-device first-load select; 0 marks the starting device |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Read word, zero when not valid |
| rd_valid | output | 1 | Read word valid, one cycle after the accepted read |
| empty | output | 1 | All devices empty |
| full | output | 1 | All devices full |
| half_full | output | 1 | More than half full (single-device mode only) |
| wr_tok | output | NUM_DEV | Write-token holder per device |
| rd_tok | output | NUM_DEV | Read-token holder per device |

## Verification
The ring checks assume that exactly one bit of `first_load_n` is 0 and that the vector stays fixed. If it does not, two starting holders would break the at-most-one-holder property and the wrap-around handoff. The bench ties the vector to a constant with only device 0 low. It drives `wr_en` and `rd_en` freely, including in the token gap cycles and against a full or empty chain, because the design must ignore those cases rather than the environment avoiding them. The random phase picks its enables from a fixed seed, so the handoff gaps land on many different enable patterns.

// File: rtl/chain_pkg.sv
package chain_pkg;

   function automatic int ring_next(input int idx, input int n);
      return (idx + 1) % n;
   endfunction

   function automatic int ring_prev(input int idx, input int n);
      return (idx + n - 1) % n;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/chain_token.sv
module chain_token #(
   parameter bit KEEP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_n,
   input  logic xi,
   input  logic last,
   output logic tok,
   output logic xo
);

   logic tok_q, xo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tok_q <= ~first_n;
         xo_q  <= 1'b0;
      end else begin
         tok_q <= KEEP ? tok_q : ((tok_q & ~last) | xi);
         xo_q  <= last & ~KEEP;
      end
   end

   assign tok = tok_q;
   assign xo  = xo_q;

   // R3
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xo |=> !xo);

   // R11
   token_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xi |-> !tok);

endmodule

// File: rtl/chain_node.sv
module chain_node #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter bit CHAINED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              wxi,
   input  logic              rxi,
   output logic              hf_wxo,
   output logic              rxo,
   output logic              wr_tok,
   output logic              rd_tok,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;
   localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP      = CW'(DEPTH);
   localparam logic [CW-1:0] HALF     = CW'(DEPTH / 2);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [CW-1:0]     cnt;
   logic              wr_fire, rd_fire, wlast, rlast;
   logic              wxo, hf;
   logic [DATA_W-1:0] rd_q;
   logic              valid_q;

   assign full    = (cnt == CAP);
   assign empty   = (cnt == '0);
   assign wr_fire = wr_en & wr_tok & ~full;
   assign rd_fire = rd_en & rd_tok & ~empty;
   assign wlast   = wr_fire & (wptr == TOP_ADDR);
   assign rlast   = rd_fire & (rptr == TOP_ADDR);

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         cnt     <= '0;
         rd_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         if (wr_fire) wptr <= wlast ? '0 : wptr + 1'b1;
         if (rd_fire) rptr <= rlast ? '0 : rptr + 1'b1;
         case ({wr_fire, rd_fire})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         rd_q    <= rd_fire ? mem[rptr] : '0;
         valid_q <= rd_fire;
      end
   end

   assign rd_data  = rd_q;
   assign rd_valid = valid_q;

   chain_token #(.KEEP(!CHAINED)) u_wtok (
      .clk(clk), .rst_n(rst_n), .first_n(first_n),
      .xi(wxi), .last(wlast), .tok(wr_tok), .xo(wxo)
   );

   chain_token #(.KEEP(!CHAINED)) u_rtok (
      .clk(clk), .rst_n(rst_n), .first_n(first_n),
      .xi(rxi), .last(rlast), .tok(rd_tok), .xo(rxo)
   );

   assign hf     = (cnt > HALF);
   assign hf_wxo = CHAINED ? wxo : hf;

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAP);

   // R6
   read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_tok && !empty));

   // R7
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_tok && !rd_en) |=> $stable(cnt));

endmodule

// File: rtl/chain_merge.sv
module chain_merge #(
   parameter int NUM_DEV = 3,
   parameter int DATA_W  = 16
) (
   input  logic [NUM_DEV-1:0]             dev_empty,
   input  logic [NUM_DEV-1:0]             dev_full,
   input  logic [NUM_DEV-1:0]             dev_valid,
   input  logic [NUM_DEV-1:0][DATA_W-1:0] dev_data,
   output logic                           empty,
   output logic                           full,
   output logic                           valid,
   output logic [DATA_W-1:0]              data
);

   assign empty = &dev_empty;
   assign full  = &dev_full;
   assign valid = |dev_valid;

   always_comb begin
      data = '0;
      for (int i = 0; i < NUM_DEV; i++) begin
         data = data | dev_data[i];
      end
   end

endmodule

// File: rtl/fifo_depth_chain.sv
module fifo_depth_chain
   import chain_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter int NUM_DEV = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] first_load_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid,
   output logic               empty,
   output logic               full,
   output logic               half_full,
   output logic [NUM_DEV-1:0] wr_tok,
   output logic [NUM_DEV-1:0] rd_tok
);

   localparam bit CHAINED = (NUM_DEV > 1);

   if (NUM_DEV < 1) begin : g_bad_count
      $error("NUM_DEV must be at least 1");
   end
   if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [NUM_DEV-1:0]             hf_wxo, rxo, wxi, rxi;
   logic [NUM_DEV-1:0]             dev_empty, dev_full, dev_valid;
   logic [NUM_DEV-1:0][DATA_W-1:0] dev_data;

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
      assign wxi[g] = CHAINED ? hf_wxo[ring_prev(g, NUM_DEV)] : 1'b0;
      assign rxi[g] = CHAINED ? rxo[ring_prev(g, NUM_DEV)]    : 1'b0;

      chain_node #(
         .DATA_W(DATA_W), .DEPTH(DEPTH), .CHAINED(CHAINED)
      ) u_node (
         .clk(clk), .rst_n(rst_n), .first_n(first_load_n[g]),
         .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
         .wxi(wxi[g]), .rxi(rxi[g]),
         .hf_wxo(hf_wxo[g]), .rxo(rxo[g]),
         .wr_tok(wr_tok[g]), .rd_tok(rd_tok[g]),
         .rd_valid(dev_valid[g]), .rd_data(dev_data[g]),
         .empty(dev_empty[g]), .full(dev_full[g])
      );

      if (CHAINED) begin : g_ring_chk
         // R3
         wr_drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wr_tok[g]) |-> hf_wxo[g]);
         // R4
         wr_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hf_wxo[g] |=> wr_tok[ring_next(g, NUM_DEV)]);
         // R5
         rd_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rxo[g] |=> rd_tok[ring_next(g, NUM_DEV)]);
      end
   end

   chain_merge #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_merge (
      .dev_empty(dev_empty), .dev_full(dev_full),
      .dev_valid(dev_valid), .dev_data(dev_data),
      .empty(empty), .full(full), .valid(rd_valid), .data(rd_data)
   );

   assign half_full = (NUM_DEV == 1) ? hf_wxo[0] : 1'b0;

   // R11
   one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_tok));

   // R11
   one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_tok));

   // R8
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_valid));

endmodule

// File: tb/sim_fifo_depth_chain.sv
`timescale 1ns/1ps
module sim_fifo_depth_chain;

   localparam int W = 16;
   localparam int D = 8;
   localparam int N = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         rd_valid, empty, full, half_full;
   logic [N-1:0] wr_tok, rd_tok;

   fifo_depth_chain #(.DATA_W(W), .DEPTH(D), .NUM_DEV(N)) u0 (
      .clk(clk), .rst_n(rst_n), .first_load_n(3'b110),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full),
      .half_full(half_full), .wr_tok(wr_tok), .rd_tok(rd_tok)
   );

   logic         s_we = 1'b0, s_re = 1'b0;
   logic [W-1:0] s_wd = '0, s_rd;
   logic         s_rv, s_empty, s_full, s_hf;
   logic [0:0]   s_wt, s_rt;

   fifo_depth_chain #(.DATA_W(W), .DEPTH(D), .NUM_DEV(1)) u1 (
      .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
      .wr_en(s_we), .wr_data(s_wd), .rd_en(s_re),
      .rd_data(s_rd), .rd_valid(s_rv), .empty(s_empty), .full(s_full),
      .half_full(s_hf), .wr_tok(s_wt), .rd_tok(s_rt)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;

   // reference model of the ring
   int cnt [N];
   int wp [N];
   int rp [N];
   int wdev = 0, rdev = 0;
   bit wgap = 0, rgap = 0;
   logic [W-1:0] q [$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] tok_exp(input bit gap, input int dev);
      return gap ? '0 : (N'(1) << dev);
   endfunction

   function automatic bit all_cnt(input int v);
      for (int i = 0; i < N; i++) if (cnt[i] != v) return 0;
      return 1;
   endfunction

   task automatic step(input bit we, input bit re, input logic [W-1:0] d);
      bit wacc, racc, wl, rl, wg0, rg0;
      logic [W-1:0] ed;
      wr_en = we; rd_en = re; wr_data = d;
      wg0  = wgap; rg0 = rgap;
      wacc = we && !wgap && cnt[wdev] < D;
      racc = re && !rgap && cnt[rdev] > 0;
      @(posedge clk); #1;
      ed = '0;
      wl = 0; rl = 0;
      if (racc) begin
         ed = q.pop_front();
         rl = (rp[rdev] == D-1);
         cnt[rdev]--; rp[rdev] = (rp[rdev] + 1) % D;
      end
      if (wacc) begin
         q.push_back(d);
         wl = (wp[wdev] == D-1);
         cnt[wdev]++; wp[wdev] = (wp[wdev] + 1) % D;
      end
      if (rg0) begin rgap = 0; rdev = (rdev + 1) % N; end
      else if (rl) rgap = 1;
      if (wg0) begin wgap = 0; wdev = (wdev + 1) % N; end
      else if (wl) wgap = 1;
      chk("R3/R4 write token", wr_tok, tok_exp(wgap, wdev));
      chk("R5 read token", rd_tok, tok_exp(rgap, rdev));
      chk("R6 read valid", rd_valid, racc);
      chk("R2/R8 read data", rd_data, ed);
      chk("R9 empty", empty, all_cnt(0));
      chk("R9 full", full, all_cnt(D));
      chk("R10 half_full low in chain", half_full, 1'b0);
      chk("R11 single holder", ($countones(wr_tok) <= 1) && ($countones(rd_tok) <= 1), 1'b1);
      if ((we && (wg0 || !wacc)) || (re && (rg0 || !racc)))
         chk("R7 ignored enable keeps state", {empty, full}, {all_cnt(0), all_cnt(D)});
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < N; i++) begin cnt[i] = 0; wp[i] = 0; rp[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset write token", wr_tok, 3'b001);
      chk("R1 reset read token", rd_tok, 3'b001);
      chk("R1 reset empty", empty, 1'b1);
      chk("R1 reset full", full, 1'b0);
      chk("R1 reset valid", rd_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset write token", wr_tok, 3'b001);
      chk("R1 after reset read token", rd_tok, 3'b001);

      // directed: fill past capacity, writes stay on through gaps and full
      for (int i = 0; i < N*D + 6; i++) step(1'b1, 1'b0, W'(16'h1000 + i));
      chk("R9 chain full after fill", full, 1'b1);
      // directed: drain past empty
      for (int i = 0; i < N*D + 6; i++) step(1'b0, 1'b1, '0);
      chk("R9 chain empty after drain", empty, 1'b1);
      // directed: simultaneous traffic across boundaries
      for (int i = 0; i < 40; i++) step(1'b1, (i > 3), W'(16'h2000 + i));
      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit we, re;
         we = ($urandom % 100) < 55;
         re = ($urandom % 100) < 50;
         step(we, re, W'($urandom));
      end
      for (int i = 0; i < N*D + 6; i++) step(1'b0, 1'b1, '0);
      chk("R8 all words returned", q.size(), 0);

      // single-device mode
      for (int i = 0; i < D + 1; i++) begin
         s_we = 1'b1; s_wd = W'(100 + i);
         @(posedge clk); #1;
         chk("R10 single half_full", s_hf, (i + 1) > D/2 && i < D ? 1'b1 : (i >= D));
         chk("R10 single token stays", {s_wt, s_rt}, 2'b11);
         @(negedge clk);
      end
      s_we = 1'b0;
      chk("R9 single full", s_full, 1'b1);
      for (int i = 0; i < D; i++) begin
         s_re = 1'b1;
         @(posedge clk); #1;
         chk("R6 single valid", s_rv, 1'b1);
         chk("R8 single order", s_rd, W'(100 + i));
         chk("R10 single half_full drain", s_hf, (D - 1 - i) > D/2);
         @(negedge clk);
      end
      s_re = 1'b0;
      chk("R9 single empty", s_empty, 1'b1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule